// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Generator

This block produces the byte that a four-channel serial controller places on the host data bus when the host acknowledges an interrupt. An arbiter outside the block chooses the winning source. The block receives that source's channel number, its source kind and a flag that says whether any source is pending. A 2-bit format control field sets how the byte is built: it can be a fixed all-ones byte, the programmable base vector unchanged, the base vector with the channel number in its low bits, or the base vector with a type code and the channel number in its low bits.

The byte is captured on the first clock edge at which acknowledge is seen high. It then holds until acknowledge drops, so changes in pending sources during the cycle cannot alter what the host reads. The bus is driven only while acknowledge and chip access are both active. At all other times the bus output floats.

Top module: `irq_vec_gen`

## Requirements
- R1: With format control 00, the captured vector is 0xFF.
- R2: With format control 01 and a source pending, the captured vector equals the base vector register unchanged.
- R3: With format control 10 and a source pending, bits 2:0 of the captured vector are {0, channel[1:0]}. Bits 7:3 come from the base vector.
- R4: With format control 11 and a source pending, bits 2:0 are {0, channel[1:0]} and bits 4:3 hold the type code. Bits 7:5 come from the base vector.
- R5: The source kind input is coded 0 = other, 1 = receiver without error, 2 = receiver with error, 3 = transmitter. The matching 2-bit type codes are 00, 10, 11 and 01.
- R6: If no source is pending when the vector is captured, the vector is 0xFF for every format control value.
- R7: The vector is captured at the first rising clock edge at which acknowledge is high. It stays unchanged at every later edge while acknowledge stays high, even when the vector inputs change.
- R8: Drive enable is high only while a vector is held, acknowledge is high and chip access is high. It falls in the same cycle that either input drops. After reset, drive enable is 0 and the held vector is 0xFF.
- R9: While drive enable is high, the bus output equals the held vector. Otherwise the bus output is high impedance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iack_act | input | 1 | Interrupt acknowledge cycle active |
| chip_sel | input | 1 | Chip access active |
| vec_ctl | input | 2 | Vector format control field |
| vec_base | input | 8 | Programmable base vector |
| src_pend | input | 1 | Some interrupt source is pending |
| src_chan | input | 2 | Channel number of the winning source |
| src_kind | input | 2 | Kind of the winning source (see R5) |
| vec_hold | output | 8 | Vector held for the current acknowledge |
| drive_en | output | 1 | Data bus drive enable |
| vec_bus | output | 8 | Tri-state data bus output |

## Verification
The assertions check on every edge that a capture with each format control value produces the byte that format calls for. They also check that the held vector does not move while acknowledge stays high, that drive enable never rises without acknowledge and chip access, and that the bus carries the held byte whenever it is driven. Some behaviours can only be shown by the bench's scenarios. These are the full sweep of channel, kind and base-vector combinations under every format, the reset values, and drive enable following chip access in the same cycle.

// File: rtl/irq_vec_pkg.sv
`timescale 1ns/1ps
package irq_vec_pkg;

   // width of the interrupt type code placed above the channel field
   localparam int TYPE_W = 2;

   typedef enum logic [1:0] {
      VFMT_NONE  = 2'b00,
      VFMT_RAW   = 2'b01,
      VFMT_CHAN  = 2'b10,
      VFMT_TYPED = 2'b11
   } vfmt_e;

   typedef enum logic [1:0] {
      KIND_OTHER  = 2'd0,
      KIND_RX_OK  = 2'd1,
      KIND_RX_ERR = 2'd2,
      KIND_TX     = 2'd3
   } src_kind_e;

   function automatic logic [TYPE_W-1:0] kind_to_code(src_kind_e k);
      case (k)
         KIND_RX_OK:  return 2'b10;
         KIND_RX_ERR: return 2'b11;
         KIND_TX:     return 2'b01;
         default:     return 2'b00;
      endcase
   endfunction

endpackage

// File: rtl/irq_vec_fmt.sv
`timescale 1ns/1ps
module irq_vec_fmt
   import irq_vec_pkg::*;
#(
   parameter int VEC_W        = 8,
   parameter int CHAN_W       = 2,
   parameter int CHAN_FIELD_W = 3
) (
   input  logic [1:0]        vec_ctl,
   input  logic [VEC_W-1:0]  vec_base,
   input  logic              src_pend,
   input  logic [CHAN_W-1:0] src_chan,
   input  logic [1:0]        src_kind,
   output logic [VEC_W-1:0]  vec_out
);

   localparam int NUM_FMT = 4;
   localparam int UPPER_C = VEC_W - CHAN_FIELD_W;
   localparam int UPPER_T = VEC_W - CHAN_FIELD_W - TYPE_W;

   if (CHAN_W >= CHAN_FIELD_W) begin : g_bad_chan
      $error("irq_vec_fmt: CHAN_W must be smaller than CHAN_FIELD_W");
   end
   if (UPPER_T < 1) begin : g_bad_vec
      $error("irq_vec_fmt: VEC_W too small for type and channel fields");
   end

   logic [CHAN_FIELD_W-1:0] chan_field;
   logic [TYPE_W-1:0]       type_code;
   logic [VEC_W-1:0]        cand [NUM_FMT];

   assign chan_field = CHAN_FIELD_W'(src_chan);
   assign type_code  = kind_to_code(src_kind_e'(src_kind));

   for (genvar f = 0; f < NUM_FMT; f++) begin : g_fmt
      if (f == int'(VFMT_NONE)) begin : g_none
         assign cand[f] = '1;
      end else if (f == int'(VFMT_RAW)) begin : g_raw
         assign cand[f] = vec_base;
      end else if (f == int'(VFMT_CHAN)) begin : g_chan
         assign cand[f] = {vec_base[VEC_W-1 -: UPPER_C], chan_field};
      end else begin : g_typed
         assign cand[f] = {vec_base[VEC_W-1 -: UPPER_T], type_code, chan_field};
      end
   end

   always_comb begin
      if (!src_pend) vec_out = '1;
      else           vec_out = cand[vec_ctl];
   end

endmodule

// File: rtl/irq_vec_hold.sv
`timescale 1ns/1ps
module irq_vec_hold #(
   parameter int VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             iack_act,
   input  logic             chip_sel,
   input  logic [VEC_W-1:0] vec_in,
   output logic [VEC_W-1:0] vec_hold,
   output logic             cap_valid,
   output logic             drive_en
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_valid <= 1'b0;
         vec_hold  <= '1;
      end else if (!iack_act) begin
         cap_valid <= 1'b0;
      end else if (!cap_valid) begin
         cap_valid <= 1'b1;
         vec_hold  <= vec_in;
      end
   end

   assign drive_en = cap_valid & iack_act & chip_sel;

endmodule

// File: rtl/irq_vec_drv.sv
`timescale 1ns/1ps
module irq_vec_drv #(
   parameter int VEC_W = 8
) (
   input  logic             drive_en,
   input  logic [VEC_W-1:0] vec_hold,
   output logic [VEC_W-1:0] vec_bus
);

   for (genvar b = 0; b < VEC_W; b++) begin : g_bit
      assign vec_bus[b] = drive_en ? vec_hold[b] : 1'bz;
   end

endmodule

// File: rtl/irq_vec_gen.sv
`timescale 1ns/1ps
module irq_vec_gen #(
   parameter int VEC_W        = 8,
   parameter int CHAN_W       = 2,
   parameter int CHAN_FIELD_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iack_act,
   input  logic              chip_sel,
   input  logic [1:0]        vec_ctl,
   input  logic [VEC_W-1:0]  vec_base,
   input  logic              src_pend,
   input  logic [CHAN_W-1:0] src_chan,
   input  logic [1:0]        src_kind,
   output logic [VEC_W-1:0]  vec_hold,
   output logic              drive_en,
   output logic [VEC_W-1:0]  vec_bus
);

   logic [VEC_W-1:0] vec_next;
   logic             cap_valid;

   irq_vec_fmt #(
      .VEC_W       (VEC_W),
      .CHAN_W      (CHAN_W),
      .CHAN_FIELD_W(CHAN_FIELD_W)
   ) u_fmt (
      .vec_ctl (vec_ctl),
      .vec_base(vec_base),
      .src_pend(src_pend),
      .src_chan(src_chan),
      .src_kind(src_kind),
      .vec_out (vec_next)
   );

   irq_vec_hold #(.VEC_W(VEC_W)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .iack_act (iack_act),
      .chip_sel (chip_sel),
      .vec_in   (vec_next),
      .vec_hold (vec_hold),
      .cap_valid(cap_valid),
      .drive_en (drive_en)
   );

   irq_vec_drv #(.VEC_W(VEC_W)) u_drv (
      .drive_en(drive_en),
      .vec_hold(vec_hold),
      .vec_bus (vec_bus)
   );

endmodule

// File: rtl/irq_vec_gen_chk.sv
`timescale 1ns/1ps
module irq_vec_gen_chk #(
   parameter int VEC_W        = 8,
   parameter int CHAN_W       = 2,
   parameter int CHAN_FIELD_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              iack_act,
   input logic              chip_sel,
   input logic [1:0]        vec_ctl,
   input logic [VEC_W-1:0]  vec_base,
   input logic              src_pend,
   input logic [CHAN_W-1:0] src_chan,
   input logic [1:0]        src_kind,
   input logic [VEC_W-1:0]  vec_hold,
   input logic              drive_en,
   input logic [VEC_W-1:0]  vec_bus,
   input logic              cap_valid
);

   localparam int HI_C = VEC_W - CHAN_FIELD_W;
   localparam int HI_T = VEC_W - CHAN_FIELD_W - 2;

   logic capture;
   assign capture = iack_act && !cap_valid;

   // R1
   fmt_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && vec_ctl == 2'b00) |=> vec_hold == {VEC_W{1'b1}});

   // R2
   fmt_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && src_pend && vec_ctl == 2'b01) |=> vec_hold == $past(vec_base));

   // R3
   fmt_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && src_pend && vec_ctl == 2'b10) |=>
         (vec_hold[CHAN_FIELD_W-1:0] == CHAN_FIELD_W'($past(src_chan)))
         && (vec_hold[VEC_W-1 -: HI_C] == $past(vec_base[VEC_W-1 -: HI_C])));

   // R4
   fmt_typed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && src_pend && vec_ctl == 2'b11) |=>
         (vec_hold[CHAN_FIELD_W-1:0] == CHAN_FIELD_W'($past(src_chan)))
         && (vec_hold[VEC_W-1 -: HI_T] == $past(vec_base[VEC_W-1 -: HI_T])));

   // R5
   type_rxerr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && src_pend && vec_ctl == 2'b11 && src_kind == 2'd2) |=>
         vec_hold[CHAN_FIELD_W+1:CHAN_FIELD_W] == 2'b11);

   // R6
   no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && !src_pend) |=> vec_hold == {VEC_W{1'b1}});

   // R7
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_valid && iack_act) |=> $stable(vec_hold));

   // R8
   drive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drive_en |-> (iack_act && chip_sel));

   // R9
   bus_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drive_en |-> vec_bus == vec_hold);

endmodule

bind irq_vec_gen irq_vec_gen_chk #(
   .VEC_W       (VEC_W),
   .CHAN_W      (CHAN_W),
   .CHAN_FIELD_W(CHAN_FIELD_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .iack_act (iack_act),
   .chip_sel (chip_sel),
   .vec_ctl  (vec_ctl),
   .vec_base (vec_base),
   .src_pend (src_pend),
   .src_chan (src_chan),
   .src_kind (src_kind),
   .vec_hold (vec_hold),
   .drive_en (drive_en),
   .vec_bus  (vec_bus),
   .cap_valid(cap_valid)
);

// File: tb/irq_vec_gen_bench.sv
`timescale 1ns/1ps
module irq_vec_gen_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       iack_act = 1'b0;
   logic       chip_sel = 1'b0;
   logic [1:0] vec_ctl = 2'b00;
   logic [7:0] vec_base = 8'h00;
   logic       src_pend = 1'b0;
   logic [1:0] src_chan = 2'd0;
   logic [1:0] src_kind = 2'd0;
   logic [7:0] vec_hold;
   logic       drive_en;
   wire  [7:0] vec_bus;

   int n_run  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   irq_vec_gen u_irq_vec_gen (
      .clk(clk), .rst_n(rst_n), .iack_act(iack_act), .chip_sel(chip_sel),
      .vec_ctl(vec_ctl), .vec_base(vec_base), .src_pend(src_pend),
      .src_chan(src_chan), .src_kind(src_kind),
      .vec_hold(vec_hold), .drive_en(drive_en), .vec_bus(vec_bus)
   );

   task automatic chk8(string req, logic [7:0] act, logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic chk1(string req, logic act, logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   function automatic logic [1:0] code_of(logic [1:0] k);
      // R5: other 00, rx ok 10, rx err 11, tx 01
      case (k)
         2'd1: return 2'b10;
         2'd2: return 2'b11;
         2'd3: return 2'b01;
         default: return 2'b00;
      endcase
   endfunction

   function automatic logic [7:0] expect_vec(logic [1:0] c, logic [7:0] b,
                                             logic p, logic [1:0] ch, logic [1:0] k);
      if (!p || c == 2'b00) return 8'hFF;
      if (c == 2'b01) return b;
      if (c == 2'b10) return (b & 8'hF8) | {6'b0, ch};
      return (b & 8'hE0) | {3'b0, code_of(k), 1'b0, ch};
   endfunction

   function automatic string tag_of(logic [1:0] c, logic p);
      if (!p) return "R6";
      case (c)
         2'b00: return "R1";
         2'b01: return "R2";
         2'b10: return "R3";
         default: return "R4/R5";
      endcase
   endfunction

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] bases [5];
      logic [7:0] exp;
      bases[0] = 8'h00; bases[1] = 8'hFF; bases[2] = 8'hA5;
      bases[3] = 8'h5A; bases[4] = 8'h3C;

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R8 reset state
      chk1("R8 reset drive_en", drive_en, 1'b0);
      chk8("R8 reset vec_hold", vec_hold, 8'hFF);

      for (int c = 0; c < 4; c++)
         for (int p = 0; p < 2; p++)
            for (int ch = 0; ch < 4; ch++)
               for (int k = 0; k < 4; k++)
                  for (int bi = 0; bi < 5; bi++) begin
                     @(negedge clk);
                     vec_ctl  = 2'(c);
                     src_pend = 1'(p);
                     src_chan = 2'(ch);
                     src_kind = 2'(k);
                     vec_base = bases[bi];
                     chip_sel = 1'b1;
                     iack_act = 1'b1;
                     exp = expect_vec(2'(c), bases[bi], 1'(p), 2'(ch), 2'(k));
                     @(negedge clk);
                     chk8(tag_of(2'(c), 1'(p)), vec_hold, exp);
                     chk1("R8 drive_en during ack", drive_en, 1'b1);
                     chk8("R9 bus value", vec_bus, exp);
                     // R7: disturb inputs, held vector must not move
                     vec_ctl  = ~vec_ctl;
                     src_pend = ~src_pend;
                     src_chan = ~src_chan;
                     src_kind = ~src_kind;
                     vec_base = ~vec_base;
                     @(negedge clk);
                     chk8("R7 hold stable", vec_hold, exp);
                     iack_act = 1'b0;
                     #1;
                     chk1("R8 drop with ack", drive_en, 1'b0);
                  end

      // R8: chip access gating within one acknowledge
      @(negedge clk);
      vec_ctl = 2'b01; src_pend = 1'b1; vec_base = 8'h42;
      chip_sel = 1'b0; iack_act = 1'b1;
      @(negedge clk);
      chk1("R8 no drive without chip_sel", drive_en, 1'b0);
      chk8("R2 captured without chip_sel", vec_hold, 8'h42);
      chip_sel = 1'b1;
      #1;
      chk1("R8 drive follows chip_sel", drive_en, 1'b1);
      chk8("R9 bus after chip_sel", vec_bus, 8'h42);
      chip_sel = 1'b0;
      #1;
      chk1("R8 drive drops with chip_sel", drive_en, 1'b0);
      @(negedge clk);
      iack_act = 1'b0;

      // R7: a new acknowledge recaptures
      @(negedge clk);
      vec_base = 8'h17; chip_sel = 1'b1; iack_act = 1'b1;
      @(negedge clk);
      chk8("R7 recapture on new ack", vec_hold, 8'h17);
      iack_act = 1'b0;
      @(negedge clk);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule